// File: doc/BRIEF.md
# I2C Single-Register Target

This block is an I2C target that holds one 8-bit value and has no sub-address pointer. It runs from a system clock and treats the bus as ordinary inputs. Both bus lines pass through a two-flop synchroniser and a glitch filter of programmable length. The block recognises START, repeated START and STOP. It compares the 7-bit address against a parameter and acknowledges when they match.

After a write address, every data byte is acknowledged and overwrites the single output register. After a read address, every byte sent on the bus is the same value. Local logic loads that value through a byte input and a one-cycle load strobe. The strobe is always accepted and cannot be back-pressured, so the edge has no valid/ready pair. The block drives SDA open-drain and never drives SCL, so clock stretching is not used. Each line has its own input, output and tristate-enable pins. Output is always 0, and an enable of 1 releases the line.

Top module: `i2cr_target`

## Requirements
- R1: While reset is held, and in the first cycle after it, both lines are released (`scl_t`=1, `sda_t`=1), and `reg_q` reads 0x00.
- R2: SCL is never driven: `scl_t` stays 1 and `scl_o` stays 0 at all times.
- R3: A bus level is taken only after FILT_LEN consecutive equal samples from the synchroniser. A 2-cycle SDA pulse while SCL is high is ignored: it creates neither STOP nor START and does not abort the byte in progress.
- R4: An address byte, sent MSB first with the R/W bit last, whose upper 7 bits equal DEV_ADDR is acknowledged by pulling SDA low during the ninth clock.
- R5: An address that does not match is not acknowledged. The block keeps SDA released until the next START or STOP, and `reg_q` is unaffected.
- R6: In a write (R/W=0), every data byte is acknowledged. `reg_q` takes the byte at its acknowledge, so after bytes 0x11 then 0xAA it holds 0xAA.
- R7: A write that carries an address but no data bytes leaves `reg_q` unchanged.
- R8: A one-cycle high on `ld_strobe` copies `ld_data` into the read register on the next clock edge.
- R9: In a read (R/W=1), every byte is sent MSB first and equals the read register. Bytes repeat while the controller acknowledges. After a NACK, SDA stays released until STOP or START.
- R10: START or repeated START in any state returns the block to address reception. STOP returns it to idle. An aborted address leaves `reg_q` untouched.
- R11: The block changes its SDA drive only while SCL is low. It holds each ACK or data bit from one SCL falling edge to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| scl_i | input | 1 | SCL line level |
| scl_o | output | 1 | SCL output value (always 0) |
| scl_t | output | 1 | SCL tristate enable, 1 = released (always 1) |
| sda_i | input | 1 | SDA line level |
| sda_o | output | 1 | SDA output value (always 0) |
| sda_t | output | 1 | SDA tristate enable, 1 = released, 0 = pull low |
| ld_data | input | 8 | Byte for later reads |
| ld_strobe | input | 1 | One-cycle load of `ld_data` into the read register |
| reg_q | output | 8 | Last byte written by the controller |

## Verification
A bus edge reaches the control engine after about 2 + FILT_LEN + 1 clocks: synchroniser, filter and edge register. The SDA drive and `reg_q` change one clock after that. The bench's bus model waits a quarter bit of 10 clocks between line changes, so every ACK and read bit it samples at mid-high has been stable for more than 10 clocks. `reg_q` is compared after a STOP, well past that latency. The read register is loaded one edge after the strobe and is checked only through a later read. A monitor flags any change of `sda_t` while both samples of the raw SCL line are high.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_WAIT
  } eng_state_t;

endpackage

// File: rtl/i2cr_pin_filter.sv
module i2cr_pin_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic level_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_r;
  logic [CW-1:0] cnt_r;
  logic          sync_q;

  assign sync_q = sync_r[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_r  <= 2'b11;
      cnt_r   <= '0;
      level_o <= 1'b1;
    end else begin
      sync_r <= {sync_r[0], pin_i};
      if (sync_q == level_o) begin
        cnt_r <= '0;
      end else if (cnt_r == CW'(FILT_LEN - 1)) begin
        level_o <= sync_q;
        cnt_r   <= '0;
      end else begin
        cnt_r <= cnt_r + 1'b1;
      end
    end
  end

  // R3: accepted level always equals the synchronised sample that qualified it
  a_r3_level_from_sync: assert property (@(posedge clk) disable iff (rst)
    !$stable(level_o) |-> level_o == $past(sync_q));

endmodule

// File: rtl/i2cr_bus_events.sv
module i2cr_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_lvl,
  input  logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_lvl;
      sda_p <= sda_lvl;
    end
  end

  assign scl_rise = scl_lvl & ~scl_p;
  assign scl_fall = ~scl_lvl & scl_p;
  assign start_ev = scl_lvl & scl_p & sda_p & ~sda_lvl;
  assign stop_ev  = scl_lvl & scl_p & ~sda_p & sda_lvl;

endmodule

// File: rtl/i2cr_engine.sv
module i2cr_engine
  import i2cr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h70
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_lvl,
  input  logic       sda_lvl,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_ev,
  input  logic       stop_ev,
  input  logic [7:0] rd_byte,
  output logic [7:0] wr_byte,
  output logic       sda_drv
);
  eng_state_t state;
  logic [3:0] bitcnt;
  logic [7:0] rx_sr, tx_sr;
  logic       rnw, mack;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      bitcnt  <= '0;
      rx_sr   <= '0;
      tx_sr   <= '0;
      rnw     <= 1'b0;
      mack    <= 1'b0;
      sda_drv <= 1'b0;
      wr_byte <= '0;
    end else if (start_ev) begin
      state   <= ST_ADDR;
      bitcnt  <= '0;
      sda_drv <= 1'b0;
    end else if (stop_ev) begin
      state   <= ST_IDLE;
      bitcnt  <= '0;
      sda_drv <= 1'b0;
    end else begin
      case (state)
        ST_ADDR: begin
          if (scl_rise) begin
            rx_sr  <= {rx_sr[6:0], sda_lvl};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == 4'd8) begin
            bitcnt <= '0;
            if (rx_sr[7:1] == DEV_ADDR) begin
              rnw     <= rx_sr[0];
              sda_drv <= 1'b1;
              state   <= ST_ADDR_ACK;
            end else begin
              state <= ST_WAIT;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            bitcnt <= '0;
            if (rnw) begin
              tx_sr   <= rd_byte;
              sda_drv <= ~rd_byte[7];
              state   <= ST_RD;
            end else begin
              sda_drv <= 1'b0;
              state   <= ST_WR;
            end
          end
        end
        ST_WR: begin
          if (scl_rise) begin
            rx_sr  <= {rx_sr[6:0], sda_lvl};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == 4'd8) begin
            bitcnt  <= '0;
            wr_byte <= rx_sr;
            sda_drv <= 1'b1;
            state   <= ST_WR_ACK;
          end
        end
        ST_WR_ACK: begin
          if (scl_fall) begin
            sda_drv <= 1'b0;
            state   <= ST_WR;
          end
        end
        ST_RD: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              bitcnt  <= '0;
              sda_drv <= 1'b0;
              state   <= ST_RD_ACK;
            end else begin
              tx_sr   <= {tx_sr[6:0], 1'b0};
              sda_drv <= ~tx_sr[6];
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            mack <= ~sda_lvl;
          end else if (scl_fall) begin
            if (mack) begin
              tx_sr   <= rd_byte;
              sda_drv <= ~rd_byte[7];
              state   <= ST_RD;
            end else begin
              state <= ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R6: the written register only moves when a data byte is acknowledged
  a_r6_update_at_ack: assert property (@(posedge clk) disable iff (rst)
    !$stable(wr_byte) |-> state == ST_WR_ACK);

  // R11: SDA drive only toggles while the filtered SCL is low
  a_r11_drive_scl_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_drv) |-> !scl_lvl);

  // R5 / R9: waiting for the end of a transaction never holds SDA low
  a_r5_wait_released: assert property (@(posedge clk) disable iff (rst)
    state == ST_WAIT |-> !sda_drv);

  // R10: any START lands in address reception with SDA released
  a_r10_start_to_addr: assert property (@(posedge clk) disable iff (rst)
    start_ev |=> (state == ST_ADDR && !sda_drv));

endmodule

// File: rtl/i2cr_target.sv
module i2cr_target #(
  parameter int         FILT_LEN = 4,
  parameter logic [6:0] DEV_ADDR = 7'h70
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  output logic       scl_o,
  output logic       scl_t,
  input  logic       sda_i,
  output logic       sda_o,
  output logic       sda_t,
  input  logic [7:0] ld_data,
  input  logic       ld_strobe,
  output logic [7:0] reg_q
);
  localparam int NPIN = 2;

  logic [NPIN-1:0] raw, lvl;
  logic            scl_rise, scl_fall, start_ev, stop_ev, sda_drv;
  logic [7:0]      rd_reg;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    i2cr_pin_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk    (clk),
      .rst    (rst),
      .pin_i  (raw[g]),
      .level_o(lvl[g])
    );
  end

  i2cr_bus_events u_events (
    .clk     (clk),
    .rst     (rst),
    .scl_lvl (lvl[1]),
    .sda_lvl (lvl[0]),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall),
    .start_ev(start_ev),
    .stop_ev (stop_ev)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_reg <= '0;
    else if (ld_strobe) rd_reg <= ld_data;
  end

  i2cr_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
    .clk     (clk),
    .rst     (rst),
    .scl_lvl (lvl[1]),
    .sda_lvl (lvl[0]),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall),
    .start_ev(start_ev),
    .stop_ev (stop_ev),
    .rd_byte (rd_reg),
    .wr_byte (reg_q),
    .sda_drv (sda_drv)
  );

  assign scl_o = 1'b0;
  assign scl_t = 1'b1;
  assign sda_o = 1'b0;
  assign sda_t = ~sda_drv;

  // R8: strobe loads the read register on the following edge
  a_r8_load: assert property (@(posedge clk) disable iff (rst)
    ld_strobe |=> rd_reg == $past(ld_data));

endmodule

// File: tb/i2cr_target_tb_top.sv
module i2cr_target_tb_top;
  localparam int         QTR  = 10;
  localparam logic [6:0] ADDR = 7'h70;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic c_scl = 1'b1, c_sda = 1'b1;
  logic scl_i, scl_o, scl_t, sda_i, sda_o, sda_t;
  logic [7:0] ld_data = '0;
  logic ld_strobe = 1'b0;
  logic [7:0] reg_q;

  int total = 0, bad = 0, viol = 0;
  bit done = 0;

  logic [7:0] exp_q[$], obs_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  assign scl_i = c_scl & (scl_t | scl_o);
  assign sda_i = c_sda & (sda_t | sda_o);

  i2cr_target #(.FILT_LEN(4), .DEV_ADDR(ADDR)) dut_i (
    .clk(clk), .rst(rst),
    .scl_i(scl_i), .scl_o(scl_o), .scl_t(scl_t),
    .sda_i(sda_i), .sda_o(sda_o), .sda_t(sda_t),
    .ld_data(ld_data), .ld_strobe(ld_strobe), .reg_q(reg_q)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    while (exp_q.size() > 0 && obs_q.size() > 0) begin
      automatic logic [7:0] e = exp_q.pop_front();
      automatic logic [7:0] o = obs_q.pop_front();
      automatic string t = tag_q.pop_front();
      chk(t, {24'd0, o}, {24'd0, e});
    end
  end

  // R11 monitor: SDA drive constant while raw SCL stays high
  logic p_scl = 1'b1, p_sdat = 1'b1;
  always @(negedge clk) begin
    if (!rst && c_scl && p_scl && sda_t !== p_sdat) viol++;
    p_scl  <= c_scl;
    p_sdat <= sda_t;
  end

  task automatic q(); repeat (QTR) @(negedge clk); endtask

  task automatic bus_start(); c_sda = 1; c_scl = 1; q(); c_sda = 0; q(); c_scl = 0; q(); endtask
  task automatic bus_rstart(); c_sda = 1; q(); c_scl = 1; q(); c_sda = 0; q(); c_scl = 0; q(); endtask
  task automatic bus_stop(); c_sda = 0; q(); c_scl = 1; q(); c_sda = 1; q(); endtask

  task automatic send_bit(input logic b, input bit glitch);
    c_sda = b; q(); c_scl = 1; q();
    if (glitch) begin
      c_sda = ~b; repeat (2) @(negedge clk); c_sda = b;
    end
    q(); c_scl = 0; q();
  endtask

  task automatic recv_bit(output logic b);
    c_sda = 1; q(); c_scl = 1; q(); b = sda_i; q(); c_scl = 0; q();
  endtask

  task automatic write_byte(input logic [7:0] v, input int glitch_bit, output bit ack);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(v[i], (7 - i) == glitch_bit);
    recv_bit(a);
    ack = (a == 1'b0);
  endtask

  task automatic read_byte(output logic [7:0] v, input bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin recv_bit(b); v[i] = b; end
    send_bit(~ack, 0);
  endtask

  task automatic load(input logic [7:0] v);
    @(negedge clk); ld_data = v; ld_strobe = 1; @(negedge clk); ld_strobe = 0;
  endtask

  task automatic expect_byte(input logic [7:0] v, input string t);
    exp_q.push_back(v); tag_q.push_back(t);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] v;
    repeat (4) @(negedge clk);
    // R1 / R2 during reset and just after
    chk("R1 sda_t in reset", sda_t, 1);
    chk("R1 reg_q in reset", reg_q, 0);
    rst = 0;
    @(negedge clk);
    chk("R1 sda_t after reset", sda_t, 1);
    chk("R2 scl_t", scl_t, 1);
    chk("R1 reg_q after reset", reg_q, 0);
    q();

    // R4 / R6: two-byte write
    bus_start();
    write_byte({ADDR, 1'b0}, -1, ack); chk("R4 address ack", ack, 1);
    write_byte(8'h11, -1, ack);        chk("R6 data ack 1", ack, 1);
    write_byte(8'hAA, -1, ack);        chk("R6 data ack 2", ack, 1);
    bus_stop(); q();
    expect_byte(8'hAA, "R6 last byte wins"); obs_q.push_back(reg_q);

    // R7: zero-length write
    bus_start();
    write_byte({ADDR, 1'b0}, -1, ack); chk("R7 address ack", ack, 1);
    bus_stop(); q();
    expect_byte(8'hAA, "R7 unchanged"); obs_q.push_back(reg_q);

    // R8 / R9: load then 4-byte read
    load(8'h55);
    bus_start();
    write_byte({ADDR, 1'b1}, -1, ack); chk("R9 read address ack", ack, 1);
    for (int k = 0; k < 4; k++) begin
      read_byte(v, k < 3);
      expect_byte(8'h55, "R9 repeated read byte"); obs_q.push_back(v);
    end
    q();
    chk("R9 released after NACK", sda_t, 1);
    bus_stop(); q();

    // R5: write to another address
    bus_start();
    write_byte({7'h55, 1'b0}, -1, ack); chk("R5 no ack write", ack, 0);
    write_byte(8'hDE, -1, ack);         chk("R5 data ignored", ack, 0);
    bus_stop(); q();
    chk("R5 reg_q kept", reg_q, 8'hAA);
    // R5: read from another address
    bus_start();
    write_byte({7'h71, 1'b1}, -1, ack); chk("R5 no ack read", ack, 0);
    read_byte(v, 0);                    chk("R5 bus idle high", v, 8'hFF);
    bus_stop(); q();

    // R10: write then repeated START read
    load(8'hC3);
    bus_start();
    write_byte({ADDR, 1'b0}, -1, ack); chk("R10 ack", ack, 1);
    write_byte(8'h3C, -1, ack);
    bus_rstart();
    write_byte({ADDR, 1'b1}, -1, ack); chk("R10 rstart ack", ack, 1);
    read_byte(v, 0);
    expect_byte(8'hC3, "R10 read after rstart"); obs_q.push_back(v);
    bus_stop(); q();
    chk("R10 reg_q after rstart", reg_q, 8'h3C);

    // R10: aborted address
    bus_start();
    send_bit(1, 0); send_bit(1, 0); send_bit(1, 0);
    bus_stop(); q();
    chk("R10 abort keeps reg_q", reg_q, 8'h3C);

    // R3: short SDA pulse on a 0 bit while SCL high
    bus_start();
    write_byte({ADDR, 1'b0}, -1, ack);
    write_byte(8'h5A, 0, ack); chk("R3 ack despite glitch", ack, 1);
    bus_stop(); q();
    chk("R3 byte survives glitch", reg_q, 8'h5A);

    chk("R11 SDA stable while SCL high", viol, 0);
    chk("R2 scl never driven", {scl_t, scl_o}, 2'b10);
    repeat (4) @(negedge clk);
    chk("scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule